// File: doc/BRIEF.md
# Flash Write-Status Poll Generator

This block models the read path of a parallel NOR flash while an internal program or erase job runs. Commands arrive as single-cycle pulses: program (address and data), erase (a mask of sectors), erase-suspend and erase-resume. A level input marks which sectors are write-protected. While a job is busy, a read of the address or sector that the job targets does not return array contents. Instead, the top data bit carries a polling flag that tells the host whether the job has finished. Reads elsewhere return the stored word. A small register array stands in for the flash cells.

For a program job the flag is the inverse of the top bit being written, and it turns true when the job ends. For an erase job the flag reads 0 while cells are being cleared and 1 once the erase is suspended. A job aimed only at protected cells still shows a busy window of a fixed length in microseconds, counted from a clock-frequency parameter, and leaves the array untouched. Status is visible from the first cycle after the command pulse is sampled.

Top module: `flash_poll_status`

## Requirements
- R1: After reset every word reads as all ones. With `rd_oe` low, `rd_data` is zero.
- R2: A program command accepted while idle starts a window of `PROG_CYC` cycles, beginning the cycle after the pulse. During this window a read of the program address returns the inverse of bit DATA_W-1 of the programmed word in that bit and zeros in all lower bits.
- R3: When the program window ends, the word holds the programmed data and reads return it.
- R4: While any job is busy, reads of addresses outside its target return the stored word.
- R5: An erase command with a nonzero sector mask starts a window of `ERASE_CYC` cycles. During this window reads anywhere in a selected sector return all zeros. When it ends, every word of each selected, unprotected sector reads all ones.
- R6: An erase leaves unselected sectors and selected protected sectors unchanged. A sector is the top `SECT_W` address bits.
- R7: A program aimed at a protected sector polls as in R2 for `CLK_MHZ` cycles (1 µs), then returns to array reads with the word unchanged.
- R8: An erase whose selected sectors are all protected reads as zero in those sectors for `100*CLK_MHZ` cycles, then returns to array reads with nothing changed.
- R9: A suspend during a real erase makes reads of selected sectors return only the top bit set (0x80 for 8-bit data). Erase progress is frozen. After a resume, the erase still totals `ERASE_CYC` busy cycles.
- R10: A program issued while suspended, to a sector outside the erase, polls as in R2 and completes as in R3. The block then returns to the suspended state.
- R11: Commands are ignored in the following cases: program or erase while a job is busy, erase with an empty mask, suspend outside a real erase, and a suspended-state program into a sector being erased.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_prog | input | 1 | Program command pulse |
| cmd_erase | input | 1 | Erase command pulse |
| cmd_suspend | input | 1 | Erase-suspend pulse |
| cmd_resume | input | 1 | Erase-resume pulse |
| cmd_addr | input | ADDR_W | Program word address |
| cmd_data | input | DATA_W | Program data |
| cmd_esel | input | 2**SECT_W | Sectors selected for erase |
| prot_mask | input | 2**SECT_W | Write-protected sectors |
| rd_oe | input | 1 | Read output enable |
| rd_addr | input | ADDR_W | Read word address |
| rd_data | output | DATA_W | Read data or polling status |

## Verification
The bench builds the block with 32 words in four sectors, `CLK_MHZ=2`, `PROG_CYC=5` and `ERASE_CYC=12`. The 1 µs and 100 µs protected windows therefore become 2 and 200 cycles. With this size, every address can be programmed with data that covers both values of the top bit. Every one of the fifteen erase masks can also be swept against two protection patterns, including the patterns where every selected sector is protected. The short windows also let the bench check each busy cycle individually and follow an erase through a suspend, a nested program and a resume.

// File: rtl/flash_poll_pkg.sv
package flash_poll_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PROG,
        ST_ERASE,
        ST_SUSP,
        ST_SUSP_PROG
    } op_state_e;

    typedef struct packed {
        logic prog_poll;
        logic prog_bit;
        logic erase_busy;
        logic erase_hold;
    } poll_flags_t;

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/flash_cell_array.sv
module flash_cell_array #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int SECT_W = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      wr_addr,
    input  logic [DATA_W-1:0]      wr_data,
    input  logic                   erase_en,
    input  logic [(1<<SECT_W)-1:0] erase_mask,
    input  logic [ADDR_W-1:0]      rd_addr,
    output logic [DATA_W-1:0]      rd_word
);
    localparam int NWORDS = 1 << ADDR_W;
    localparam int OFS_W  = ADDR_W - SECT_W;

    logic [DATA_W-1:0] cells [NWORDS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int w = 0; w < NWORDS; w++) cells[w] <= '1;
        end else if (wr_en) begin
            cells[wr_addr] <= wr_data;
        end else if (erase_en) begin
            for (int w = 0; w < NWORDS; w++) begin
                if (erase_mask[w >> OFS_W]) cells[w] <= '1;
            end
        end
    end

    assign rd_word = cells[rd_addr];

    // R6
    one_update_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({wr_en, erase_en}));

endmodule

// File: rtl/flash_op_ctrl.sv
module flash_op_ctrl
    import flash_poll_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 8,
    parameter int SECT_W    = 2,
    parameter int CLK_MHZ   = 100,
    parameter int PROG_CYC  = 700,
    parameter int ERASE_CYC = 5000
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cmd_prog,
    input  logic                   cmd_erase,
    input  logic                   cmd_suspend,
    input  logic                   cmd_resume,
    input  logic [ADDR_W-1:0]      cmd_addr,
    input  logic [DATA_W-1:0]      cmd_data,
    input  logic [(1<<SECT_W)-1:0] cmd_esel,
    input  logic [(1<<SECT_W)-1:0] prot_mask,
    output logic                   wr_en,
    output logic [ADDR_W-1:0]      job_addr,
    output logic [DATA_W-1:0]      job_data,
    output logic                   erase_en,
    output logic [(1<<SECT_W)-1:0] erase_clr,
    output logic [(1<<SECT_W)-1:0] erase_sel,
    output poll_flags_t            flags
);
    localparam int NSECT      = 1 << SECT_W;
    localparam int PROT_PROG  = CLK_MHZ;
    localparam int PROT_ERASE = CLK_MHZ * 100;
    localparam int MAXC       = max2(max2(PROG_CYC, ERASE_CYC), max2(PROT_PROG, PROT_ERASE));
    localparam int CW         = $clog2(MAXC + 1);

    op_state_e         state_q;
    logic [CW-1:0]     pcnt_q, ecnt_q;
    logic              pfake_q, efake_q;
    logic [ADDR_W-1:0] paddr_q;
    logic [DATA_W-1:0] pdata_q;
    logic [NSECT-1:0]  esel_q, eclr_q;

    logic [SECT_W-1:0] cmd_sect;
    logic              cmd_prot, cmd_in_erase;
    logic              take_prog, take_sprog, take_erase, take_susp, take_resume;
    logic              prog_last, erase_last;
    logic [CW-1:0]     prog_load;
    logic [NSECT-1:0]  clr_new;

    always_comb begin
        cmd_sect     = cmd_addr[ADDR_W-1 -: SECT_W];
        cmd_prot     = prot_mask[cmd_sect];
        cmd_in_erase = esel_q[cmd_sect];
        clr_new      = cmd_esel & ~prot_mask;
        prog_load    = cmd_prot ? CW'(PROT_PROG - 1) : CW'(PROG_CYC - 1);
        take_prog    = (state_q == ST_IDLE) && cmd_prog;
        take_erase   = (state_q == ST_IDLE) && !cmd_prog && cmd_erase && (cmd_esel != '0);
        take_susp    = (state_q == ST_ERASE) && !efake_q && cmd_suspend && (ecnt_q != '0);
        take_sprog   = (state_q == ST_SUSP) && cmd_prog && !cmd_in_erase;
        take_resume  = (state_q == ST_SUSP) && cmd_resume && !take_sprog;
        prog_last    = ((state_q == ST_PROG) || (state_q == ST_SUSP_PROG)) && (pcnt_q == '0);
        erase_last   = (state_q == ST_ERASE) && (ecnt_q == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            pcnt_q  <= '0;
            ecnt_q  <= '0;
            pfake_q <= 1'b0;
            efake_q <= 1'b0;
            paddr_q <= '0;
            pdata_q <= '0;
            esel_q  <= '0;
            eclr_q  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (take_prog) begin
                        state_q <= ST_PROG;
                        pcnt_q  <= prog_load;
                        pfake_q <= cmd_prot;
                        paddr_q <= cmd_addr;
                        pdata_q <= cmd_data;
                    end else if (take_erase) begin
                        state_q <= ST_ERASE;
                        esel_q  <= cmd_esel;
                        eclr_q  <= clr_new;
                        efake_q <= (clr_new == '0);
                        ecnt_q  <= (clr_new == '0) ? CW'(PROT_ERASE - 1) : CW'(ERASE_CYC - 1);
                    end
                end
                ST_PROG: begin
                    if (pcnt_q == '0) state_q <= ST_IDLE;
                    else              pcnt_q  <= pcnt_q - 1'b1;
                end
                ST_ERASE: begin
                    if (ecnt_q == '0) begin
                        state_q <= ST_IDLE;
                        esel_q  <= '0;
                    end else begin
                        ecnt_q <= ecnt_q - 1'b1;
                        if (take_susp) state_q <= ST_SUSP;
                    end
                end
                ST_SUSP: begin
                    if (take_sprog) begin
                        state_q <= ST_SUSP_PROG;
                        pcnt_q  <= prog_load;
                        pfake_q <= cmd_prot;
                        paddr_q <= cmd_addr;
                        pdata_q <= cmd_data;
                    end else if (take_resume) begin
                        state_q <= ST_ERASE;
                    end
                end
                ST_SUSP_PROG: begin
                    if (pcnt_q == '0) state_q <= ST_SUSP;
                    else              pcnt_q  <= pcnt_q - 1'b1;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign wr_en     = prog_last && !pfake_q;
    assign erase_en  = erase_last && !efake_q;
    assign job_addr  = paddr_q;
    assign job_data  = pdata_q;
    assign erase_clr = eclr_q;
    assign erase_sel = esel_q;

    always_comb begin
        flags.prog_poll  = (state_q == ST_PROG) || (state_q == ST_SUSP_PROG);
        flags.prog_bit   = pdata_q[DATA_W-1];
        flags.erase_busy = (state_q == ST_ERASE);
        flags.erase_hold = (state_q == ST_SUSP) || (state_q == ST_SUSP_PROG);
    end

    // R3
    prog_finish_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_PROG && pcnt_q == '0) |=> (state_q == ST_IDLE));

    // R10
    sprog_return_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SUSP_PROG && pcnt_q == '0) |=> (state_q == ST_SUSP));

    // R9
    susp_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SUSP) |=> (state_q == ST_SUSP_PROG || state_q == ST_ERASE || $stable(ecnt_q)));

    // R11
    busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ERASE && ecnt_q != '0 && !cmd_suspend) |=> (state_q == ST_ERASE));

    // R5
    erase_finish_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ERASE && ecnt_q == '0) |=> (state_q == ST_IDLE));

endmodule

// File: rtl/flash_status_mux.sv
module flash_status_mux
    import flash_poll_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int SECT_W = 2
) (
    input  logic                   rd_oe,
    input  logic [ADDR_W-1:0]      rd_addr,
    input  logic [DATA_W-1:0]      array_word,
    input  logic [ADDR_W-1:0]      job_addr,
    input  logic [(1<<SECT_W)-1:0] erase_sel,
    input  poll_flags_t            flags,
    output logic [DATA_W-1:0]      rd_data
);
    logic [SECT_W-1:0] rd_sect;
    logic              hit_prog, hit_erase;

    always_comb begin
        rd_sect   = rd_addr[ADDR_W-1 -: SECT_W];
        hit_prog  = flags.prog_poll && (rd_addr == job_addr);
        hit_erase = erase_sel[rd_sect];
        rd_data   = '0;
        if (!rd_oe) begin
            rd_data = '0;
        end else if (hit_prog) begin
            rd_data[DATA_W-1] = ~flags.prog_bit;
        end else if (flags.erase_busy && hit_erase) begin
            rd_data = '0;
        end else if (flags.erase_hold && hit_erase) begin
            rd_data[DATA_W-1] = 1'b1;
        end else begin
            rd_data = array_word;
        end
    end

endmodule

// File: rtl/flash_poll_status.sv
module flash_poll_status
    import flash_poll_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 8,
    parameter int SECT_W    = 2,
    parameter int CLK_MHZ   = 100,
    parameter int PROG_CYC  = 700,
    parameter int ERASE_CYC = 5000
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cmd_prog,
    input  logic                   cmd_erase,
    input  logic                   cmd_suspend,
    input  logic                   cmd_resume,
    input  logic [ADDR_W-1:0]      cmd_addr,
    input  logic [DATA_W-1:0]      cmd_data,
    input  logic [(1<<SECT_W)-1:0] cmd_esel,
    input  logic [(1<<SECT_W)-1:0] prot_mask,
    input  logic                   rd_oe,
    input  logic [ADDR_W-1:0]      rd_addr,
    output logic [DATA_W-1:0]      rd_data
);
    localparam int NSECT = 1 << SECT_W;

    logic              wr_en, erase_en;
    logic [ADDR_W-1:0] job_addr;
    logic [DATA_W-1:0] job_data, array_word;
    logic [NSECT-1:0]  erase_clr, erase_sel;
    poll_flags_t       flags;

    flash_op_ctrl #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_W(SECT_W),
        .CLK_MHZ(CLK_MHZ), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)
    ) u_ctrl (
        .clk(clk), .rst(rst),
        .cmd_prog(cmd_prog), .cmd_erase(cmd_erase),
        .cmd_suspend(cmd_suspend), .cmd_resume(cmd_resume),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data),
        .cmd_esel(cmd_esel), .prot_mask(prot_mask),
        .wr_en(wr_en), .job_addr(job_addr), .job_data(job_data),
        .erase_en(erase_en), .erase_clr(erase_clr), .erase_sel(erase_sel),
        .flags(flags)
    );

    flash_cell_array #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_W(SECT_W)
    ) u_array (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_addr(job_addr), .wr_data(job_data),
        .erase_en(erase_en), .erase_mask(erase_clr),
        .rd_addr(rd_addr), .rd_word(array_word)
    );

    flash_status_mux #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_W(SECT_W)
    ) u_mux (
        .rd_oe(rd_oe), .rd_addr(rd_addr), .array_word(array_word),
        .job_addr(job_addr), .erase_sel(erase_sel), .flags(flags),
        .rd_data(rd_data)
    );

endmodule

// File: tb/flash_poll_status_test.sv
module flash_poll_status_test;
    localparam int AW = 5, DW = 8, SW = 2, MHZ = 2, PC = 5, EC = 12;
    localparam int PP = MHZ, EP = MHZ * 100, NW = 1 << AW, WPS = NW >> SW;

    logic clk = 1'b0, rst = 1'b1;
    logic cmd_prog = 0, cmd_erase = 0, cmd_suspend = 0, cmd_resume = 0;
    logic [AW-1:0] cmd_addr = '0, rd_addr = '0;
    logic [DW-1:0] cmd_data = '0;
    logic [3:0] cmd_esel = '0, prot_mask = '0;
    logic rd_oe = 1'b0;
    logic [DW-1:0] rd_data;
    logic [DW-1:0] em [NW];
    int total = 0, bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    flash_poll_status #(.ADDR_W(AW), .DATA_W(DW), .SECT_W(SW), .CLK_MHZ(MHZ),
                        .PROG_CYC(PC), .ERASE_CYC(EC)) uut (
        .clk(clk), .rst(rst), .cmd_prog(cmd_prog), .cmd_erase(cmd_erase),
        .cmd_suspend(cmd_suspend), .cmd_resume(cmd_resume), .cmd_addr(cmd_addr),
        .cmd_data(cmd_data), .cmd_esel(cmd_esel), .prot_mask(prot_mask),
        .rd_oe(rd_oe), .rd_addr(rd_addr), .rd_data(rd_data));

    function automatic logic [DW-1:0] pat(input int a, input int k);
        return DW'((a * 37 + k * 91 + 5) & 8'hFF);
    endfunction

    function automatic logic [DW-1:0] poll(input logic [DW-1:0] d);
        return {~d[DW-1], {(DW-1){1'b0}}};
    endfunction

    task automatic look(input string tag, input int a, input logic [DW-1:0] exp);
        rd_addr = AW'(a); rd_oe = 1'b1; #1;
        total++;
        if (rd_data !== exp) begin
            bad++;
            $display("FAIL %s addr=%0d act=%h exp=%h", tag, a, rd_data, exp);
        end
    endtask

    task automatic sweep(input string tag);
        for (int a = 0; a < NW; a++) look(tag, a, em[a]);
    endtask

    task automatic prog_pulse(input int a, input logic [DW-1:0] d);
        cmd_addr = AW'(a); cmd_data = d; cmd_prog = 1'b1;
        @(negedge clk); cmd_prog = 1'b0;
    endtask

    task automatic erase_pulse(input logic [3:0] m);
        cmd_esel = m; cmd_erase = 1'b1;
        @(negedge clk); cmd_erase = 1'b0;
    endtask

    task automatic fill_all(input int k);
        for (int a = 0; a < NW; a++) begin
            prog_pulse(a, pat(a, k));
            repeat (PC) @(negedge clk);
            em[a] = pat(a, k);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog act=hung exp=finished");
        finish_run();
    end

    initial begin
        for (int a = 0; a < NW; a++) em[a] = '1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        sweep("R1 reset contents");
        rd_oe = 1'b0; #1;
        total++;
        if (rd_data !== '0) begin bad++; $display("FAIL R1 oe low act=%h exp=00", rd_data); end
        @(negedge clk);

        // R2 R3 R4 R11: program every address; busy-time erase/program must be ignored
        for (int a = 0; a < NW; a++) begin
            logic [DW-1:0] d;
            d = pat(a, 1);
            prog_pulse(a, d);
            for (int i = 0; i < PC; i++) begin
                look("R2 program poll", a, poll(d));
                look("R4 other read", (a + 9) % NW, em[(a + 9) % NW]);
                cmd_erase = (i == 1); cmd_esel = 4'hF;
                cmd_prog = (i == 2); cmd_addr = AW'((a + 3) % NW); cmd_data = 8'h00;
                @(negedge clk);
                cmd_erase = 1'b0; cmd_prog = 1'b0; cmd_addr = AW'(a);
            end
            em[a] = d;
            look("R3 program result", a, d);
        end
        @(negedge clk);
        sweep("R11 busy commands ignored");
        @(negedge clk);

        // R7: protected-sector program
        prot_mask = 4'b0010;
        for (int a = WPS; a < 2 * WPS; a++) begin
            logic [DW-1:0] d;
            d = pat(a, 2);
            prog_pulse(a, d);
            for (int i = 0; i < PP; i++) begin
                look("R7 protected poll", a, poll(d));
                @(negedge clk);
            end
            look("R7 protected unchanged", a, em[a]);
        end
        @(negedge clk);

        // R5 R6 R8: all masks against two protection patterns
        for (int p = 0; p < 2; p++) begin
            for (int m = 1; m < 16; m++) begin
                logic [3:0] pm, clr;
                pm = (p == 0) ? 4'b0000 : 4'b0101;
                prot_mask = 4'b0000;
                fill_all(m + 3 * p);
                prot_mask = pm;
                clr = 4'(m) & ~pm;
                erase_pulse(4'(m));
                if (clr == 4'b0) begin
                    for (int i = 0; i < EP; i++) begin
                        for (int s = 0; s < 4; s++)
                            if (m[s]) look("R8 all-protected poll", s * WPS + 2, 8'h00);
                        @(negedge clk);
                    end
                    sweep("R8 nothing changed");
                end else begin
                    for (int i = 0; i < EC; i++) begin
                        for (int s = 0; s < 4; s++)
                            look(m[s] ? "R5 erase poll" : "R4 unselected read",
                                 s * WPS + (i % WPS), m[s] ? 8'h00 : em[s * WPS + (i % WPS)]);
                        @(negedge clk);
                    end
                    for (int a = 0; a < NW; a++) if (clr[a / WPS]) em[a] = '1;
                    sweep("R5 R6 erase result");
                end
                @(negedge clk);
            end
        end

        // R11: empty erase mask and idle suspend ignored
        prot_mask = 4'b0000;
        fill_all(7);
        erase_pulse(4'b0000);
        look("R11 empty mask", 1, em[1]);
        cmd_suspend = 1'b1; @(negedge clk); cmd_suspend = 1'b0;
        look("R11 idle suspend", 2, em[2]);
        @(negedge clk);

        // R9 R10 R11: suspend, nested program, resume
        erase_pulse(4'b0001);
        for (int i = 0; i < 4; i++) begin
            look("R9 erase before suspend", i, 8'h00);
            @(negedge clk);
        end
        look("R9 erase before suspend", 4, 8'h00);
        cmd_suspend = 1'b1; @(negedge clk); cmd_suspend = 1'b0;
        for (int i = 0; i < 3; i++) begin
            look("R9 suspended poll", 3, 8'h80);
            look("R9 outside sector", 20, em[20]);
            @(negedge clk);
        end
        prog_pulse(2, 8'h11);
        look("R11 program into erased sector ignored", 2, 8'h80);
        @(negedge clk);
        begin
            logic [DW-1:0] d;
            d = 8'h5A;
            prog_pulse(17, d);
            for (int i = 0; i < PC; i++) begin
                look("R10 suspended program poll", 17, poll(d));
                look("R10 erase still held", 1, 8'h80);
                @(negedge clk);
            end
            em[17] = d;
            look("R10 suspended program result", 17, d);
            look("R10 back to suspend", 0, 8'h80);
            d = 8'hA5;
            prog_pulse(18, d);
            look("R10 second suspended program poll", 18, poll(d));
            repeat (PC) @(negedge clk);
            em[18] = d;
            look("R10 second result", 18, d);
        end
        cmd_resume = 1'b1; @(negedge clk); cmd_resume = 1'b0;
        for (int i = 0; i < EC - 5; i++) begin
            look("R9 resumed erase poll", 7, 8'h00);
            @(negedge clk);
        end
        for (int a = 0; a < WPS; a++) em[a] = '1;
        sweep("R9 erase after resume");

        finish_run();
    end
endmodule